// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit up-counters behind one synchronous register port. All channels run from the same clock. Each channel has its own optional power-of-two prescaler, its own control bits and an interval limit. A channel can count freely and wrap at the top of its range. It can instead restart from zero when it reaches its interval limit, and each such restart raises a status flag.

Software programs the channels through byte addresses, with the channels' registers interleaved at a 4-byte step. It reads the counter at any time. It acknowledges an interval event by reading the status register, and that read clears the flag. Each channel drives one level-sensitive interrupt line, and the enable register masks that line.

Top module: `tck_triple_timer`

## Requirements
- R1: In free-running mode (control bit 1 = 0), a counter advances by one per tick and goes from 0xFFFF to 0.
- R2: Timing register bit 0 turns the prescaler on, and bits [4:1] hold an exponent N. With the prescaler on, the counter advances once every 2^(N+1) clocks. With it off, the counter advances every clock.
- R3: While control bit 0 is 1, the counter is halted and keeps its value.
- R4: Writing 1 to control bit 4 sets the counter to 0 and restarts the prescaler phase. Bit 4 always reads back as 0. Bits 0, 1, 2, 3 and 5 read back as written.
- R5: In interval mode (control bit 1 = 1), a tick that finds the count equal to the interval register sets the count to 0 and sets status bit 0. Free-running mode never sets status.
- R6: Reading the status register returns the pending flags and clears them. A flag raised in the same cycle as the read stays pending.
- R7: A channel's interrupt output is 1 exactly when a status bit and the matching enable bit are both 1. Enable value 0 keeps the output at 0 while status stays pending.
- R8: Channel c uses these addresses: timing 0x00+4c, control 0x0C+4c, count 0x18+4c (read-only), interval 0x24+4c, status 0x54+4c (read-only), enable 0x60+4c. A write reaches only the channel it addresses.
- R9: After reset every counter is halted at 0 with control value 0x01. The timing register is 0 and the interval is 0xFFFF. Status and enable are 0, and all interrupt outputs are low.
- R10: Read data appears on the cycle after the read strobe. Unmapped addresses read as 0. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 3 | Level interrupt, one bit per channel |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit count and a 4-bit prescaler exponent. With these values a full 65,536-tick wrap fits into one run. The prescaler tests use exponents 0 and 2, so their periods of 2 and 8 clocks are short enough to count tick by tick. An interval limit of 1 makes an event land on every second tick. That spacing places a status read on the same edge as a new event, so the read-versus-set race can be checked.

// File: rtl/tck_pkg.sv
package tck_pkg;
  // register slots inside one channel
  localparam int RI_CLK = 0;
  localparam int RI_CTL = 1;
  localparam int RI_VAL = 2;
  localparam int RI_IVL = 3;
  localparam int RI_STS = 4;
  localparam int RI_IEN = 5;
  localparam int RI_N   = 6;
  localparam int CH_STRIDE = 4;

  // byte offset of a register slot for channel 0
  function automatic logic [7:0] reg_off(input int idx);
    case (idx)
      RI_CLK:  return 8'h00;
      RI_CTL:  return 8'h0C;
      RI_VAL:  return 8'h18;
      RI_IVL:  return 8'h24;
      RI_STS:  return 8'h54;
      default: return 8'h60;
    endcase
  endfunction

  // last prescaler phase for exponent n: period is 2^(n+1) clocks
  function automatic logic [31:0] presc_last(input logic [31:0] n);
    return (32'd1 << (n + 32'd1)) - 32'd1;
  endfunction
endpackage

// File: rtl/tck_prescaler.sv
module tck_prescaler #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pre_en,
  input  logic [NW-1:0] pre_exp,
  input  logic          clr,
  output logic          tick
);
  localparam int PW = 2 ** NW;

  logic [PW-1:0] pcnt;
  logic [31:0]   last_full;
  logic          at_last;

  assign last_full = tck_pkg::presc_last(32'(pre_exp));
  assign at_last   = (32'(pcnt) == last_full);
  assign tick      = run && (!pre_en || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt <= '0;
    else if (clr || !run || !pre_en) pcnt <= '0;
    else if (at_last)                pcnt <= '0;
    else                             pcnt <= pcnt + PW'(1);
  end

  // R2: a prescaled tick is never followed directly by another one
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pre_en && !clr |=> !tick);
endmodule

// File: rtl/tck_channel.sv
module tck_channel #(
  parameter int CW = 16,
  parameter int NW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_clk,
  input  logic                         wr_ctl,
  input  logic                         wr_ivl,
  input  logic                         wr_ien,
  input  logic                         rd_sts,
  input  logic [CW-1:0]                wdata,
  output logic [tck_pkg::RI_N-1:0][CW-1:0] rv,
  output logic                         irq
);
  import tck_pkg::*;

  localparam int TW = NW + 1;

  logic [TW-1:0] clk_q;
  logic [5:0]    ctl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] ivl_q;
  logic [5:0]    sts_q;
  logic [5:0]    ien_q;

  // named internal events
  logic cnt_rst_wr, run, imode, tick, match, wrap_ivl, presc_clr;
  logic [5:0] sts_set;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] lim,
                                               input logic restart_mode);
    if (restart_mode && cur == lim) return '0;
    return cur + CW'(1);
  endfunction

  assign cnt_rst_wr = wr_ctl && wdata[4];
  assign run        = !ctl_q[0];
  assign imode      = ctl_q[1];
  assign match      = (cnt_q == ivl_q);
  assign wrap_ivl   = tick && imode && match;
  assign sts_set    = {5'b0, wrap_ivl && !cnt_rst_wr};
  assign presc_clr  = wr_clk || cnt_rst_wr;

  tck_prescaler #(.NW(NW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pre_en  (clk_q[0]),
    .pre_exp (clk_q[TW-1:1]),
    .clr     (presc_clr),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ctl_q <= 6'h01;
      ivl_q <= '1;
      ien_q <= '0;
    end else begin
      if (wr_clk) clk_q <= wdata[TW-1:0];
      if (wr_ctl) ctl_q <= wdata[5:0] & 6'h2F;
      if (wr_ivl) ivl_q <= wdata;
      if (wr_ien) ien_q <= wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_rst_wr) cnt_q <= '0;
    else if (tick)       cnt_q <= next_count(cnt_q, ivl_q, imode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (rd_sts ? 6'h00 : sts_q) | sts_set;
  end

  always_comb begin
    rv         = '0;
    rv[RI_CLK] = CW'(clk_q);
    rv[RI_CTL] = CW'(ctl_q);
    rv[RI_VAL] = cnt_q;
    rv[RI_IVL] = ivl_q;
    rv[RI_STS] = CW'(sts_q);
    rv[RI_IEN] = CW'(ien_q);
  end

  assign irq = |(sts_q & ien_q);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !imode && !cnt_rst_wr && cnt_q == '1 |=> cnt_q == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_rst_wr |=> $stable(cnt_q));
  p_rst_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_wr |=> cnt_q == '0);
  p_ivl_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ivl && !cnt_rst_wr |=> cnt_q == '0 && sts_q[0]);
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts && !sts_set[0] |=> sts_q == 6'h00);
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ien_q == 6'h00 |-> !irq);
endmodule

// File: rtl/tck_triple_timer.sv
module tck_triple_timer #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int NW  = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  output logic [NCH-1:0] irq
);
  import tck_pkg::*;

  logic [NCH-1:0][RI_N-1:0]          hit;
  logic [NCH-1:0][RI_N-1:0][CW-1:0]  rv_all;
  logic [CW-1:0]                     rmux;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < RI_N; r++)
        hit[c][r] = (addr == AW'(32'(reg_off(r)) + 32'(c * CH_STRIDE)));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tck_channel #(.CW(CW), .NW(NW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_clk (wr_en && hit[c][RI_CLK]),
      .wr_ctl (wr_en && hit[c][RI_CTL]),
      .wr_ivl (wr_en && hit[c][RI_IVL]),
      .wr_ien (wr_en && hit[c][RI_IEN]),
      .rd_sts (rd_en && hit[c][RI_STS]),
      .wdata  (wdata),
      .rv     (rv_all[c]),
      .irq    (irq[c])
    );
  end

  always_comb begin
    rmux = '0;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < RI_N; r++)
        if (hit[c][r]) rmux = rv_all[c][r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end

  // R8: one address never selects two registers
  p_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(hit) <= 1);
  // R10: read data only moves after a read strobe
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tck_triple_timer_bench.sv
module tck_triple_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] rv;

  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_VAL = 8'h18,
                         A_IVL = 8'h24, A_STS = 8'h54, A_IEN = 8'h60;

  tck_triple_timer u_tck_triple_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(A_CTL, rv);     chk("R9 ctl", rv, 16'h0001);
    rd(A_IVL + 4, rv); chk("R9 ivl ch1", rv, 16'hFFFF);
    rd(A_CLK + 8, rv); chk("R9 clk ch2", rv, 16'h0000);
    rd(A_VAL, rv);     chk("R9 count", rv, 16'h0000);
    rd(A_IEN, rv);     chk("R9 ien", rv, 16'h0000);
    chk("R9 irq", irq, 3'b000);
    rd(8'h30, rv);     chk("R10 unmapped", rv, 16'h0000);
  endtask

  task automatic t_readback;
    wr(A_CTL + 4, 16'h0032);
    rd(A_CTL + 4, rv); chk("R4 bit4 self-clear", rv, 16'h0022);
    wr(A_IVL + 4, 16'h1234);
    rd(A_IVL + 4, rv); chk("R8 ivl ch1", rv, 16'h1234);
    rd(A_IVL, rv);     chk("R8 ivl ch0 untouched", rv, 16'hFFFF);
    wr(A_CTL + 4, 16'h0001);
  endtask

  task automatic t_freerun;
    wr(A_CTL, 16'h0010);
    idle(65535);
    rd(A_VAL, rv); chk("R1 top", rv, 16'hFFFF);
    rd(A_VAL, rv); chk("R1 wrap", rv, 16'h0000);
    rd(A_STS, rv); chk("R5 free no status", rv, 16'h0000);
  endtask

  task automatic t_hold;
    wr(A_CTL, 16'h0010);
    idle(4);
    wr(A_CTL, 16'h0001);
    idle(10);
    rd(A_VAL, rv); chk("R3 halted", rv, 16'd5);
    rd(A_VAL, rv); chk("R3 still", rv, 16'd5);
  endtask

  task automatic t_prescale;
    wr(A_CLK, 16'h0001);
    wr(A_CTL, 16'h0010);
    idle(10);
    rd(A_VAL, rv); chk("R2 div2", rv, 16'd5);
    rd(A_VAL, rv); chk("R2 div2 phase", rv, 16'd5);
    wr(A_CLK, 16'h0005);
    wr(A_CTL, 16'h0010);
    idle(24);
    rd(A_VAL, rv); chk("R2 div8", rv, 16'd3);
    wr(A_CLK, 16'h0000);
  endtask

  task automatic t_interval;
    wr(A_IEN, 16'h0001);
    wr(A_IVL, 16'd3);
    wr(A_CTL, 16'h0012);
    idle(3);
    chk("R5 no early flag", irq[0], 1'b0);
    idle(1);
    chk("R7 irq on match", irq[0], 1'b1);
    rd(A_VAL, rv); chk("R5 restart", rv, 16'd0);
    rd(A_STS, rv); chk("R6 status read", rv, 16'h0001);
    chk("R6 cleared", irq[0], 1'b0);
  endtask

  task automatic t_same_cycle;
    wr(A_IVL, 16'd1);
    wr(A_CTL, 16'h0012);
    rd(A_STS, rv);
    idle(2);
    rd(A_STS, rv); chk("R6 read with set", rv, 16'h0001);
    chk("R6 set stays", irq[0], 1'b1);
    rd(A_STS, rv); chk("R6 pending", rv, 16'h0001);
    chk("R6 now clear", irq[0], 1'b0);
  endtask

  task automatic t_mask;
    logic [15:0] v1;
    wr(A_IEN, 16'h0000);
    idle(3);
    chk("R7 masked", irq[0], 1'b0);
    rd(A_STS, rv); chk("R7 status kept", rv, 16'h0001);
    chk("R8 ch2 quiet", irq[2], 1'b0);
    wr(A_CTL, 16'h0001);
    rd(A_VAL, v1);
    wr(A_VAL, 16'hAAAA);
    rd(A_VAL, rv); chk("R10 ro write ignored", rv, v1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_readback;
    t_freerun;
    t_hold;
    t_prescale;
    t_interval;
    t_same_cycle;
    t_mask;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule